// File: doc/BRIEF.md
# Flash Command Interface and Program/Erase Sequencer

This block holds the control side of a small flash memory. A host bus with address, write data, read data, an active-low write strobe and an active-low output enable is sampled in the block's clock domain. Each completed write cycle is taken at the rising edge of the write strobe and decoded as a command. Two-cycle commands start a byte program or a block erase, which then run as timed internal sequences. A status register reports readiness, erase suspension and sticky error flags. The storage itself is a small register array. Supply health, programming-voltage health and a reset-pin high-voltage override come in as digital inputs, as do the per-block lock bits.

A running erase can be paused. While it is paused the host may read the array, read status, and program bytes in other blocks, then resume the erase. A resume given while such a program is still running is held until that program finishes. Program and erase durations are parameters counted in clock cycles. The suspend latency is a small fixed count.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset every byte reads FFh, reads return array data, and a read-status command (70h) then shows status 80h.
- R2: A byte program is a setup write of 40h (or 10h) followed by an address/data write. When it completes, the byte holds its old value AND the written data.
- R3: After a setup write, reads return status. Status bit 7 (ready) is 0 while a program or erase runs and 1 when idle. Bit 6 is erase-suspended, bit 5 erase error, bit 4 program error, bit 3 programming-voltage error, bit 1 lock error, and bits 2 and 0 read 0.
- R4: An erase is 20h followed by D0h. It sets every byte of the 16-byte block holding the address to FFh and leaves other blocks unchanged. Any other second byte sets bits 4 and 5 and erases nothing.
- R5: An operation on a block whose lock input is 1 while the reset-pin high-voltage input is 0 does not modify the array. It sets bits 1 and 5 for an erase, or bits 1 and 4 for a program. With the high-voltage input at 1 the operation proceeds.
- R6: With programming voltage not OK, an erase sets bits 3 and 5 and a program sets bits 3 and 4. The array is not modified. This check takes precedence over the lock check.
- R7: Error bits 1, 3, 4 and 5 stay set through later commands and clear only on a clear-status write (50h).
- R8: While a byte program runs, command writes are ignored and reads keep returning status.
- R9: Writing B0h during an erase halts it. After the suspend latency, status reads C0h and the erase makes no progress.
- R10: While suspended, FFh, 70h and program setup are accepted. A program aimed at the suspended block is dropped without error or change. A program to another block completes.
- R11: D0h while suspended resumes the erase. If a program is running, bit 6 stays 1 until that program completes. Then bit 6 clears, bit 7 reads 0, and the erase finishes.
- R12: While the supply-OK input is 0, all bus writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | AW | Byte address |
| din | input | 8 | Write data / command byte |
| we_n | input | 1 | Active-low write strobe; the cycle is taken at its rising edge |
| oe_n | input | 1 | Active-low output enable |
| dout | output | 8 | Array byte or status; 00h while oe_n is high |
| vcc_ok | input | 1 | Supply within range |
| vpp_ok | input | 1 | Programming voltage valid |
| rp_hv | input | 1 | Reset pin at high voltage; overrides lock bits |
| lock_bits | input | 2**(AW-BW) | Lock bit per block |

## Verification
The hardest state to reach is a byte program running inside an erase suspension, with a resume command already waiting behind it. The stimulus starts an erase, suspends it, and waits out the latency. It then starts a program in a different block and issues D0h while that program still runs. Status must read 40h in that window, then 00h once the erase restarts. The last reads show the erased block all FFh and the programmed byte intact.

// File: rtl/flash_pkg.sv
package flash_pkg;
  localparam logic [7:0] CMD_RD_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_RD_STAT  = 8'h70;
  localparam logic [7:0] CMD_CLR_STAT = 8'h50;
  localparam logic [7:0] CMD_PROG     = 8'h40;
  localparam logic [7:0] CMD_PROG_ALT = 8'h10;
  localparam logic [7:0] CMD_ERASE    = 8'h20;
  localparam logic [7:0] CMD_CONFIRM  = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND  = 8'hB0;

  typedef enum logic [1:0] {CS_IDLE, CS_PROG, CS_ERASE} cmd_st_e;

  // programming can only clear bits
  function automatic logic [7:0] prog_merge(input logic [7:0] old_b, input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  function automatic logic [7:0] pack_status(input logic rdy, input logic susp,
                                             input logic e_er, input logic e_pg,
                                             input logic e_vpp, input logic e_lock);
    return {rdy, susp, e_er, e_pg, e_vpp, 1'b0, e_lock, 1'b0};
  endfunction
endpackage

// File: rtl/flash_we_edge.sv
module flash_we_edge #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic          stb,
  output logic [AW-1:0] a_q,
  output logic [7:0]    d_q
);
  logic we_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b1;
      stb  <= 1'b0;
      a_q  <= '0;
      d_q  <= '0;
    end else begin
      we_q <= we_n;
      stb  <= we_n & ~we_q;
      a_q  <= addr;
      d_q  <= din;
    end
  end
endmodule

// File: rtl/flash_down_cnt.sv
module flash_down_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          hold,
  output logic          done
);
  logic [CW-1:0] cnt;
  assign done = (cnt == CW'(1)) && !hold;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (load)                cnt <= load_val;
    else if (cnt != '0 && !hold)  cnt <= cnt - CW'(1);
  end
endmodule

// File: rtl/flash_array.sv
module flash_array
  import flash_pkg::*;
#(
  parameter int AW = 6,
  parameter int BW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    rd_addr,
  output logic [7:0]       rd_data,
  input  logic             pg_en,
  input  logic [AW-1:0]    pg_addr,
  input  logic [7:0]       pg_data,
  input  logic             er_en,
  input  logic [AW-BW-1:0] er_blk
);
  localparam int NB = 1 << AW;
  logic [7:0] mem [NB];

  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) mem[i] <= 8'hFF;
    end else begin
      for (int i = 0; i < NB; i++) begin
        if (er_en && (AW'(i) >> BW) == AW'(er_blk))
          mem[i] <= 8'hFF;
        else if (pg_en && pg_addr == AW'(i))
          mem[i] <= prog_merge(mem[i], pg_data);
      end
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_pkg::*;
#(
  parameter int AW        = 6,
  parameter int BW        = 4,
  parameter int PROG_CYC  = 12,
  parameter int ERASE_CYC = 48,
  parameter int SUSP_LAT  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [AW-1:0]          addr,
  input  logic [7:0]             din,
  input  logic                   we_n,
  input  logic                   oe_n,
  output logic [7:0]             dout,
  input  logic                   vcc_ok,
  input  logic                   vpp_ok,
  input  logic                   rp_hv,
  input  logic [(1<<(AW-BW))-1:0] lock_bits
);
  localparam int BKW  = AW - BW;
  localparam int CMAX = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int SW   = $clog2(SUSP_LAT + 1);

  logic          stb;
  logic [AW-1:0] a_q;
  logic [7:0]    d_q;

  flash_we_edge #(.AW(AW)) u_edge (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .addr(addr), .din(din),
    .stb(stb), .a_q(a_q), .d_q(d_q)
  );

  cmd_st_e        cst, cst_n;
  logic           rd_stat, rd_n;
  logic           pg_run, er_run, er_susp, sp_pend, rs_pend;
  logic [SW-1:0]  sp_cnt;
  logic [AW-1:0]  pg_addr;
  logic [7:0]     pg_data;
  logic [BKW-1:0] er_blk;
  logic           e1, e3, e4, e5;

  // named events for the checker
  logic ev_prog_start, ev_erase_start, ev_clear, ev_susp_req, ev_resume_req;
  logic ev_prog_done, ev_erase_done;
  logic set_e1, set_e3, set_e4, set_e5;

  wire            wr_go   = stb && vcc_ok;
  wire [BKW-1:0]  a_blk   = a_q[AW-1:BW];
  wire            locked_a = lock_bits[a_blk] && !rp_hv;
  wire            is_prog = (d_q == CMD_PROG) || (d_q == CMD_PROG_ALT);

  always_comb begin
    cst_n = cst;  rd_n = rd_stat;
    ev_prog_start = 1'b0; ev_erase_start = 1'b0; ev_clear = 1'b0;
    ev_susp_req = 1'b0;   ev_resume_req = 1'b0;
    set_e1 = 1'b0; set_e3 = 1'b0; set_e4 = 1'b0; set_e5 = 1'b0;
    if (wr_go) begin
      unique case (cst)
        CS_PROG: begin
          cst_n = CS_IDLE;
          if (er_run && a_blk == er_blk) begin
            // program into the suspended block is dropped
          end else if (!vpp_ok) begin
            set_e3 = 1'b1; set_e4 = 1'b1;
          end else if (locked_a) begin
            set_e1 = 1'b1; set_e4 = 1'b1;
          end else ev_prog_start = 1'b1;
        end
        CS_ERASE: begin
          cst_n = CS_IDLE;
          if (d_q != CMD_CONFIRM) begin
            set_e4 = 1'b1; set_e5 = 1'b1;
          end else if (!vpp_ok) begin
            set_e3 = 1'b1; set_e5 = 1'b1;
          end else if (locked_a) begin
            set_e1 = 1'b1; set_e5 = 1'b1;
          end else ev_erase_start = 1'b1;
        end
        default: begin
          if (er_susp) begin
            if (d_q == CMD_CONFIRM) begin
              if (!rs_pend) ev_resume_req = 1'b1;
            end else if (!pg_run) begin
              if (d_q == CMD_RD_ARRAY)     rd_n = 1'b0;
              else if (d_q == CMD_RD_STAT) rd_n = 1'b1;
              else if (is_prog) begin cst_n = CS_PROG; rd_n = 1'b1; end
            end
          end else if (pg_run) begin
            // busy: ignore
          end else if (er_run) begin
            if (d_q == CMD_SUSPEND && !sp_pend) ev_susp_req = 1'b1;
          end else begin
            if (d_q == CMD_RD_ARRAY)       rd_n = 1'b0;
            else if (d_q == CMD_RD_STAT)   rd_n = 1'b1;
            else if (d_q == CMD_CLR_STAT)  ev_clear = 1'b1;
            else if (is_prog)   begin cst_n = CS_PROG;  rd_n = 1'b1; end
            else if (d_q == CMD_ERASE) begin cst_n = CS_ERASE; rd_n = 1'b1; end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cst <= CS_IDLE; rd_stat <= 1'b0;
      pg_run <= 1'b0; er_run <= 1'b0; er_susp <= 1'b0;
      sp_pend <= 1'b0; rs_pend <= 1'b0; sp_cnt <= '0;
      pg_addr <= '0; pg_data <= '0; er_blk <= '0;
      e1 <= 1'b0; e3 <= 1'b0; e4 <= 1'b0; e5 <= 1'b0;
    end else begin
      cst <= cst_n; rd_stat <= rd_n;
      e1 <= !ev_clear && (e1 || set_e1);
      e3 <= !ev_clear && (e3 || set_e3);
      e4 <= !ev_clear && (e4 || set_e4);
      e5 <= !ev_clear && (e5 || set_e5);
      if (ev_prog_start) begin
        pg_run <= 1'b1; pg_addr <= a_q; pg_data <= d_q;
      end else if (ev_prog_done) pg_run <= 1'b0;
      if (ev_erase_start) begin
        er_run <= 1'b1; er_blk <= a_blk;
      end else if (ev_erase_done) er_run <= 1'b0;
      if (ev_susp_req) begin
        sp_pend <= 1'b1; sp_cnt <= SW'(SUSP_LAT);
      end else if (sp_pend) begin
        if (sp_cnt == SW'(1)) begin sp_pend <= 1'b0; er_susp <= 1'b1; end
        else sp_cnt <= sp_cnt - SW'(1);
      end
      if (ev_resume_req) rs_pend <= 1'b1;
      else if (rs_pend && !pg_run) begin rs_pend <= 1'b0; er_susp <= 1'b0; end
    end
  end

  flash_down_cnt #(.CW(CW)) u_pg_tmr (
    .clk(clk), .rst_n(rst_n), .load(ev_prog_start), .load_val(CW'(PROG_CYC)),
    .hold(1'b0), .done(ev_prog_done)
  );

  flash_down_cnt #(.CW(CW)) u_er_tmr (
    .clk(clk), .rst_n(rst_n), .load(ev_erase_start), .load_val(CW'(ERASE_CYC)),
    .hold(sp_pend | er_susp), .done(ev_erase_done)
  );

  logic [7:0] arr_rd;
  flash_array #(.AW(AW), .BW(BW)) u_arr (
    .clk(clk), .rst_n(rst_n), .rd_addr(addr), .rd_data(arr_rd),
    .pg_en(ev_prog_done), .pg_addr(pg_addr), .pg_data(pg_data),
    .er_en(ev_erase_done), .er_blk(er_blk)
  );

  wire        ready  = !pg_run && (!er_run || er_susp);
  wire [7:0]  status = pack_status(ready, er_susp, e5, e4, e3, e1);

  assign dout = oe_n ? 8'h00 : (rd_stat ? status : arr_rd);
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] status,
  input logic       pg_run,
  input logic       er_run,
  input logic       sp_pend,
  input logic       ev_prog_start,
  input logic       ev_erase_start,
  input logic       ev_clear,
  input logic       vpp_ok,
  input logic       locked_a
);
  p_busy_after_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_prog_start |=> !status[7]);

  p_lock_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_prog_start || ev_erase_start) |-> !locked_a);

  p_vpp_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_prog_start || ev_erase_start) |-> vpp_ok);

  p_sticky_errors_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(status[5:1]) & ~status[5:1])) |-> $past(ev_clear));

  p_susp_has_erase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    status[6] |-> er_run);

  p_susp_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[6]) |-> $past(sp_pend));

  p_resume_waits_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[6]) |-> !$past(pg_run));
endmodule

bind flash_cmd_seq flash_cmd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .status(status), .pg_run(pg_run), .er_run(er_run),
  .sp_pend(sp_pend), .ev_prog_start(ev_prog_start), .ev_erase_start(ev_erase_start),
  .ev_clear(ev_clear), .vpp_ok(vpp_ok), .locked_a(locked_a)
);

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
  localparam int CLK_PER = 10;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic          we_n = 1'b1, oe_n = 1'b1;
  logic          vcc_ok = 1'b1, vpp_ok = 1'b1, rp_hv = 1'b0;
  logic [3:0]    lock_bits = 4'b0000;
  logic [7:0]    dout;

  flash_cmd_seq #(.AW(AW), .BW(4), .PROG_CYC(20), .ERASE_CYC(60), .SUSP_LAT(3)) i_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .we_n(we_n), .oe_n(oe_n),
    .dout(dout), .vcc_ok(vcc_ok), .vpp_ok(vpp_ok), .rp_hv(rp_hv), .lock_bits(lock_bits)
  );

  typedef struct { logic [7:0] val; string tag; } exp_t;
  exp_t q[$];
  int   total = 0, bad = 0;
  logic mon_req = 1'b0;
  logic done_flag = 1'b0;

  // monitor: pops the expected item and compares a quarter period after the edge
  always @(posedge clk) begin
    if (mon_req) begin
      #(CLK_PER/4);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (dout !== e.val) begin
          bad++;
          $display("FAIL %s: got %02h expected %02h", e.tag, dout, e.val);
        end
      end
    end
  end

  task automatic chk(input logic [AW-1:0] a, input logic [7:0] v, input string tag);
    exp_t e;
    @(negedge clk);
    addr = a; oe_n = 1'b0;
    e.val = v; e.tag = tag;
    q.push_back(e);
    mon_req = 1'b1;
    @(negedge clk);
    mon_req = 1'b0; oe_n = 1'b1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; din = d; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_bit(input int b, input logic v, input string tag);
    bit hit = 1'b0;
    oe_n = 1'b0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (dout[b] === v) begin hit = 1'b1; break; end
    end
    oe_n = 1'b1;
    if (!hit) begin
      total++; bad++;
      $display("FAIL %s: status bit %0d got %b expected %b", tag, b, dout[b], v);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PER * 100000);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(0, 8'hFF, "R1 array byte 0");
    chk(6'h3F, 8'hFF, "R1 array last byte");
    wr(0, 8'h70);
    chk(0, 8'h80, "R1 status after reset");

    // R2 / R3 program and status
    wr(1, 8'h40); wr(1, 8'h5A);
    chk(0, 8'h00, "R3 busy during program");
    wait_bit(7, 1'b1, "R3 ready");
    chk(0, 8'h80, "R3 ready status");
    wr(0, 8'hFF);
    chk(1, 8'h5A, "R2 programmed byte");
    wr(1, 8'h40); wr(1, 8'h0F);
    wait_bit(7, 1'b1, "R2 ready");
    wr(0, 8'hFF);
    chk(1, 8'h0A, "R2 AND merge");

    // R8 busy ignore, alternate setup code
    wr(6'h32, 8'h10); wr(6'h32, 8'h11);
    wr(0, 8'hFF);
    chk(0, 8'h00, "R8 write ignored while busy");
    wait_bit(7, 1'b1, "R8 ready");
    chk(0, 8'h80, "R8 still status mode");
    wr(0, 8'hFF);
    chk(6'h32, 8'h11, "R2 alternate setup");

    // R4 bad confirm
    wr(0, 8'h20); wr(0, 8'h33);
    chk(0, 8'hB0, "R4 bad confirm bits");
    wr(0, 8'hFF);
    chk(1, 8'h0A, "R4 no erase on bad confirm");
    // R7 sticky
    wr(0, 8'h70);
    chk(0, 8'hB0, "R7 bits held");
    wr(0, 8'h50);
    chk(0, 8'h80, "R7 cleared by 50h");

    // R5 lock
    lock_bits = 4'b0100; rp_hv = 1'b1;
    wr(6'h20, 8'h40); wr(6'h20, 8'h3C);
    wait_bit(7, 1'b1, "R5 ready");
    chk(0, 8'h80, "R5 override by high voltage");
    rp_hv = 1'b0;
    wr(6'h20, 8'h40); wr(6'h20, 8'h00);
    chk(0, 8'h92, "R5 program lock bits");
    wr(6'h20, 8'h20); wr(6'h20, 8'hD0);
    chk(0, 8'hB2, "R5 erase lock bits");
    wr(0, 8'hFF);
    chk(6'h20, 8'h3C, "R5 locked block unchanged");
    wr(0, 8'h50); wr(0, 8'h70);
    chk(0, 8'h80, "R7 clear after lock errors");

    // R6 programming voltage
    vpp_ok = 1'b0;
    wr(6'h30, 8'h40); wr(6'h30, 8'h00);
    chk(0, 8'h98, "R6 program vpp bits");
    wr(0, 8'h50);
    wr(6'h20, 8'h20); wr(6'h20, 8'hD0);
    chk(0, 8'hA8, "R6 erase vpp bits");
    wr(0, 8'hFF);
    chk(6'h30, 8'hFF, "R6 program blocked");
    chk(6'h20, 8'h3C, "R6 erase blocked");
    wr(0, 8'h50); wr(0, 8'h70);
    vpp_ok = 1'b1; lock_bits = 4'b0000;

    // R12 supply low
    vcc_ok = 1'b0;
    wr(0, 8'hFF);
    chk(1, 8'h80, "R12 mode change ignored");
    wr(6'h31, 8'h40); wr(6'h31, 8'h00);
    vcc_ok = 1'b1;
    wr(0, 8'hFF);
    chk(6'h31, 8'hFF, "R12 program ignored");

    // R9 - R11 suspend / resume
    wr(0, 8'h20); wr(0, 8'hD0);
    wr(0, 8'hB0);
    repeat (10) @(negedge clk);
    chk(0, 8'hC0, "R9 suspended status");
    wr(2, 8'h40); wr(2, 8'h00);
    chk(0, 8'hC0, "R10 same-block program dropped");
    wr(0, 8'hFF);
    chk(1, 8'h0A, "R9 erase halted");
    chk(2, 8'hFF, "R10 suspended block untouched");
    wr(6'h11, 8'h40); wr(6'h11, 8'h77);
    wr(0, 8'hD0);
    chk(0, 8'h40, "R11 resume deferred");
    wait_bit(6, 1'b0, "R11 resume");
    chk(0, 8'h00, "R11 erase running again");
    wait_bit(7, 1'b1, "R11 erase done");
    chk(0, 8'h80, "R11 ready after erase");
    wr(0, 8'hFF);
    chk(1, 8'hFF, "R4 erased byte");
    chk(6'h0F, 8'hFF, "R4 block end erased");
    chk(6'h11, 8'h77, "R10 other block program");
    chk(6'h20, 8'h3C, "R4 other block kept");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule